// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small microcontroller datapath. Each clock it takes two byte operands, a 4-bit operation code, and the current carry and zero flags. One clock later it presents a result byte and six status flags, together with a per-flag write-enable mask. The mask tells the status register which flags this operation changes. A separate write-back strobe tells the register file whether the result should be stored.

The operations are:
- add, and add with carry in
- subtract, and subtract with borrow in
- AND, OR and XOR
- ones' complement and twos' complement negate
- increment and decrement
- compare, and compare with borrow in

Each operation touches its own subset of flags. Subtract-with-borrow and compare-with-borrow chain the zero flag across bytes, so that multi-byte subtractions and compares give a correct zero indication for the whole word. The unary operations act on operand A.

Top module: `alu8_core`

## Requirements
- R1: All outputs are registered: the response to the inputs present at a rising clock edge appears after that edge. While `rst` is high at an edge, every output is cleared to zero.
- R2: The flag bits are placed as follows: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H. The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, COM=7, NEG=8, INC=9, DEC=10, CMP=11, CPC=12. ADD, ADC, SUB, SBC, NEG, CMP and CPC drive a write mask of 0x3F.
- R3: ADD computes A+B and ADC computes A+B+c_i, both modulo 256. For these, C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow.
- R4: SUB and CMP compute A-B; SBC and CPC compute A-B-c_i. For these, C is the borrow out of bit 7, H is the borrow into bit 4, and V flags signed overflow.
- R5: AND, OR and XOR drive a mask of 0x1E, which leaves C and H unwritten, and they clear V.
- R6: COM returns 0xFF-A (the bitwise inverse of A), sets C to 1, and drives a mask of 0x1F (H unwritten).
- R7: NEG returns 0x00-A, and its flags follow the subtraction rules of R4 with a zero minuend.
- R8: INC returns A+1 and DEC returns A-1. Both drive a mask of 0x1E. V is set only for INC of 0x7F and DEC of 0x80.
- R9: For every operation, N is bit 7 of the result and S equals N XOR V. Z is 1 when the result is zero, except as stated in R10. Any flag bit outside the mask reads 0.
- R10: For SBC and CPC, Z is 1 only when the result is zero and z_i is 1.
- R11: `wr_o` is 0 for CMP and CPC and 1 for every other defined code.
- R12: Codes 13 to 15 have no effect: mask 0, `wr_o` 0, result 0, flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (R2) |
| a_i | input | 8 | Operand A; the operand of unary operations |
| b_i | input | 8 | Operand B |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag, used for chaining |
| result_o | output | 8 | Result byte |
| flags_o | output | 6 | Flag values (bit layout in R2); bits outside the mask read 0 |
| flag_we_o | output | 6 | Per-flag write enables |
| wr_o | output | 1 | Write-back strobe for the result |

## Verification
The bench builds the block at its default width of 8 bits. At this width the signed-overflow boundaries (0x7F and 0x80), the nibble carry out of bit 3, and the borrow chains through c_i and z_i can all be hit directly by directed cases. Random bytes are mixed in for every operation code with both values of c_i and z_i, and each result is compared with a bench model that works in integer arithmetic.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    localparam int FLAG_N = 6;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_ADC = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_SBC = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_OR  = 4'd5;
    localparam logic [3:0] OP_XOR = 4'd6;
    localparam logic [3:0] OP_COM = 4'd7;
    localparam logic [3:0] OP_NEG = 4'd8;
    localparam logic [3:0] OP_INC = 4'd9;
    localparam logic [3:0] OP_DEC = 4'd10;
    localparam logic [3:0] OP_CMP = 4'd11;
    localparam logic [3:0] OP_CPC = 4'd12;

    localparam logic [FLAG_N-1:0] MASK_ALL   = 6'h3F;
    localparam logic [FLAG_N-1:0] MASK_LOGIC = 6'h1E;
    localparam logic [FLAG_N-1:0] MASK_COM   = 6'h1F;

    typedef enum logic [1:0] {
        U_NONE  = 2'd0,
        U_ARITH = 2'd1,
        U_LOGIC = 2'd2,
        U_COM   = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        B_OPND = 2'd0,
        B_ONE  = 2'd1,
        B_A    = 2'd2
    } bsrc_e;

    typedef enum logic [1:0] {
        L_AND = 2'd0,
        L_OR  = 2'd1,
        L_XOR = 2'd2,
        L_NOT = 2'd3
    } lsel_e;

    // bit 0 carry ... bit 5 half carry
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        unit_e             unit;
        bsrc_e             bsrc;
        lsel_e             lsel;
        logic              a_zero;
        logic              sub;
        logic              use_c;
        logic              zchain;
        logic              wr;
        logic [FLAG_N-1:0] mask;
    } ctl_t;

    function automatic logic is_logic_op(input logic [3:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_cmp_op(input logic [3:0] op);
        return (op == OP_CMP) || (op == OP_CPC);
    endfunction

endpackage

// File: rtl/alu8_decode.sv
`timescale 1ns/1ps
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op,
    output ctl_t       ctl
);
    always_comb begin
        ctl        = '0;
        ctl.unit   = U_NONE;
        ctl.bsrc   = B_OPND;
        ctl.lsel   = L_AND;
        case (op)
            OP_ADD, OP_ADC: begin
                ctl.unit  = U_ARITH;
                ctl.use_c = (op == OP_ADC);
                ctl.wr    = 1'b1;
                ctl.mask  = MASK_ALL;
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
                ctl.unit   = U_ARITH;
                ctl.sub    = 1'b1;
                ctl.use_c  = (op == OP_SBC) || (op == OP_CPC);
                ctl.zchain = (op == OP_SBC) || (op == OP_CPC);
                ctl.wr     = !is_cmp_op(op);
                ctl.mask   = MASK_ALL;
            end
            OP_NEG: begin
                ctl.unit   = U_ARITH;
                ctl.sub    = 1'b1;
                ctl.a_zero = 1'b1;
                ctl.bsrc   = B_A;
                ctl.wr     = 1'b1;
                ctl.mask   = MASK_ALL;
            end
            OP_INC, OP_DEC: begin
                ctl.unit = U_ARITH;
                ctl.sub  = (op == OP_DEC);
                ctl.bsrc = B_ONE;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_LOGIC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                ctl.unit = U_LOGIC;
                ctl.lsel = (op == OP_AND) ? L_AND : (op == OP_OR) ? L_OR : L_XOR;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_LOGIC;
            end
            OP_COM: begin
                ctl.unit = U_COM;
                ctl.lsel = L_NOT;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_COM;
            end
            default: ctl.unit = U_NONE;
        endcase
    end
endmodule

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             h_out,
    output logic             v_out
);
    localparam int NIB = WIDTH / 2;
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full;
    logic [NIB:0]   low;

    always_comb begin
        if (sub) begin
            full  = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
            low   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
            v_out = (a[MSB] ^ b[MSB]) & (full[MSB] ^ a[MSB]);
        end else begin
            full  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
            low   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
            v_out = ~(a[MSB] ^ b[MSB]) & (full[MSB] ^ a[MSB]);
        end
        sum   = full[WIDTH-1:0];
        c_out = full[WIDTH];
        h_out = low[NIB];
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  lsel_e            sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (sel)
            L_AND:   y = a & b;
            L_OR:    y = a | b;
            L_XOR:   y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [WIDTH-1:0]  result_o,
    output logic [FLAG_N-1:0] flags_o,
    output logic [FLAG_N-1:0] flag_we_o,
    output logic              wr_o
);
    localparam int MSB = WIDTH - 1;

    ctl_t             ctl;
    logic [WIDTH-1:0] op_a, op_b, sum, lres, res;
    logic             cin, c_out, h_out, v_out;
    flags_t           fl;

    alu8_decode u_dec (.op(op_i), .ctl(ctl));

    always_comb begin
        op_a = ctl.a_zero ? '0 : a_i;
        case (ctl.bsrc)
            B_ONE:   op_b = {{(WIDTH-1){1'b0}}, 1'b1};
            B_A:     op_b = a_i;
            default: op_b = b_i;
        endcase
        cin = ctl.use_c & c_i;
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_as (
        .a(op_a), .b(op_b), .cin(cin), .sub(ctl.sub),
        .sum(sum), .c_out(c_out), .h_out(h_out), .v_out(v_out)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_lg (
        .a(a_i), .b(b_i), .sel(ctl.lsel), .y(lres)
    );

    always_comb begin
        case (ctl.unit)
            U_ARITH:        res = sum;
            U_LOGIC, U_COM: res = lres;
            default:        res = '0;
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0) && (!ctl.zchain || z_i);
        fl.v = (ctl.unit == U_ARITH) ? v_out : 1'b0;
        fl.c = (ctl.unit == U_COM) ? 1'b1 : c_out;
        fl.h = h_out;
        fl.s = fl.n ^ fl.v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            flags_o   <= '0;
            flag_we_o <= '0;
            wr_o      <= 1'b0;
        end else begin
            result_o  <= res;
            flags_o   <= fl & ctl.mask;
            flag_we_o <= ctl.mask;
            wr_o      <= ctl.wr;
        end
    end

    // R5: logic codes leave C and H alone and clear V
    p_logic_mask_r5: assert property (@(posedge clk) disable iff (rst)
        is_logic_op(op_i) |=> (flag_we_o == MASK_LOGIC) && !flags_o[3]);

    // R6: ones' complement forces the carry
    p_com_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_COM) |=> flags_o[0] && (flag_we_o == MASK_COM));

    // R9: sign flag relation on every written flag set
    p_sign_rel_r9: assert property (@(posedge clk) disable iff (rst)
        flag_we_o[4] |-> (flags_o[4] == (flags_o[2] ^ flags_o[3])));

    // R9: unwritten flags read zero
    p_unmasked_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (flags_o & ~flag_we_o) == '0);

    // R10: cleared incoming zero stays cleared in the chain
    p_zchain_r10: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_SBC) || (op_i == OP_CPC)) && !z_i |=> !flags_o[1]);

    // R11: compares never write back
    p_cmp_nowr_r11: assert property (@(posedge clk) disable iff (rst)
        is_cmp_op(op_i) |=> !wr_o);

    // R12: undefined codes do nothing
    p_undef_r12: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_CPC) |=> (flag_we_o == '0) && !wr_o);
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0, b_i = 8'd0;
    logic       c_i = 1'b0, z_i = 1'b0;
    logic [7:0] result_o;
    logic [5:0] flags_o, flag_we_o;
    logic       wr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] e_res;
    logic [5:0] e_fl, e_we;
    logic       e_wr;

    always #2.5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .c_i(c_i), .z_i(z_i), .result_o(result_o), .flags_o(flags_o),
        .flag_we_o(flag_we_o), .wr_o(wr_o)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    task automatic model(input int op, input int a, input int b, input int c, input int z);
        int full, r, sf, hc, zf;
        bit cf, vf, hf, chain;
        cf = 0; vf = 0; hf = 0; chain = 0; r = 0;
        e_we = 6'h00; e_wr = 1'b1;
        case (op)
            0, 1: begin
                if (op == 0) c = 0;
                full = a + b + c; r = full & 255; cf = full > 255;
                hc = (a % 16) + (b % 16) + c; hf = hc > 15;
                sf = sgn(a) + sgn(b) + c; vf = (sf > 127) || (sf < -128);
                e_we = 6'h3F;
            end
            2, 3, 8, 11, 12: begin
                if (op == 8) begin b = a; a = 0; end
                if (op == 2 || op == 8 || op == 11) c = 0;
                chain = (op == 3) || (op == 12);
                full = a - b - c; r = (full + 256) & 255; cf = full < 0;
                hc = (a % 16) - (b % 16) - c; hf = hc < 0;
                sf = sgn(a) - sgn(b) - c; vf = (sf > 127) || (sf < -128);
                e_we = 6'h3F;
                e_wr = !(op == 11 || op == 12);
            end
            4: begin r = a & b; e_we = 6'h1E; end
            5: begin r = a | b; e_we = 6'h1E; end
            6: begin r = a ^ b; e_we = 6'h1E; end
            7: begin r = 255 - a; cf = 1; e_we = 6'h1F; end
            9: begin r = (a + 1) & 255; vf = (a == 127); e_we = 6'h1E; end
            10: begin r = (a + 255) & 255; vf = (a == 128); e_we = 6'h1E; end
            default: begin r = 0; e_wr = 1'b0; end
        endcase
        zf = (r == 0) && (!chain || z != 0);
        e_res = r[7:0];
        e_fl  = {hf, (r > 127) ^ vf, vf, r > 127, zf[0], cf} & e_we;
    endtask

    task automatic apply(input int op, input int a, input int b, input int c,
                         input int z, input string req);
        @(negedge clk);
        op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0]; z_i = z[0];
        model(op, a, b, c, z);
        @(posedge clk);
        #1;
        checks++;
        if (flags_o !== e_fl || flag_we_o !== e_we || wr_o !== e_wr ||
            ((e_wr || op > 12) && result_o !== e_res)) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h c=%0d z=%0d: res=%h fl=%h we=%h wr=%0d expected res=%h fl=%h we=%h wr=%0d",
                     req, op, a, b, c, z, result_o, flags_o, flag_we_o, wr_o,
                     e_res, e_fl, e_we, e_wr);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result_o !== 8'h00 || flags_o !== 6'h00 || flag_we_o !== 6'h00 || wr_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: res=%h fl=%h we=%h wr=%0d expected all 0",
                     result_o, flags_o, flag_we_o, wr_o);
        end
        @(negedge clk);
        rst = 1'b0;

        apply(0, 8'h7F, 8'h01, 0, 0, "R3 add overflow");
        apply(0, 8'h0F, 8'h01, 0, 0, "R3 half carry");
        apply(1, 8'hFF, 8'h00, 1, 0, "R3 adc carry zero");
        apply(0, 8'h80, 8'h80, 1, 0, "R2 add ignores carry in");
        apply(2, 8'h00, 8'h01, 0, 0, "R4 sub borrow");
        apply(2, 8'h80, 8'h01, 0, 0, "R4 sub overflow");
        apply(3, 8'h10, 8'h00, 1, 1, "R4 sbc half borrow");
        apply(3, 8'h05, 8'h04, 1, 1, "R10 sbc zero kept");
        apply(3, 8'h05, 8'h04, 1, 0, "R10 sbc zero chain clear");
        apply(12, 8'h05, 8'h05, 0, 1, "R10 cpc zero kept");
        apply(12, 8'h05, 8'h05, 0, 0, "R10 cpc chain clear");
        apply(11, 8'h42, 8'h42, 1, 0, "R11 cmp no write");
        apply(4, 8'hF0, 8'h0F, 1, 0, "R5 and zero");
        apply(5, 8'h80, 8'h01, 0, 0, "R5 or negative");
        apply(6, 8'hAA, 8'hAA, 0, 0, "R5 xor zero");
        apply(7, 8'hFF, 8'h00, 0, 0, "R6 com zero");
        apply(7, 8'h00, 8'h00, 0, 0, "R6 com all ones");
        apply(8, 8'h80, 8'h00, 0, 0, "R7 neg min");
        apply(8, 8'h00, 8'h00, 1, 0, "R7 neg zero");
        apply(8, 8'h01, 8'h00, 0, 0, "R7 neg one");
        apply(9, 8'h7F, 8'h00, 1, 0, "R8 inc overflow");
        apply(9, 8'hFF, 8'h00, 0, 0, "R8 inc wrap");
        apply(10, 8'h80, 8'h00, 1, 0, "R8 dec overflow");
        apply(10, 8'h01, 8'h00, 0, 0, "R8 dec zero");
        apply(13, 8'h12, 8'h34, 1, 1, "R12 undefined 13");
        apply(15, 8'hFF, 8'hFF, 1, 1, "R12 undefined 15");
        apply(14, 8'h00, 8'h00, 0, 0, "R12 undefined 14");

        for (int i = 0; i < 3000; i++) begin
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), i % 2, (i / 2) % 2,
                  "R2 R9 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (flag_we_o !== 6'h00 || wr_o !== 1'b0 || result_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 re-reset: res=%h we=%h wr=%0d expected 0", result_o, flag_we_o, wr_o);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule